// File: doc/BRIEF.md
# Floating-Point Status Word and Exception Accumulator

This block holds the upper 32-bit status word of a floating-point unit. From that word it decodes the rounding direction and the flush-to-zero control and drives them to the arithmetic datapath. When the arithmetic unit finishes an operation, it pulses a completion strobe together with five raw exception flags. The block moves those flags into fixed sticky positions at the top of the status word.

An operation that raises an exception whose enable bit is set in the low five bits of the same word causes the block to raise an assist trap. The trap is a single-cycle pulse. Software writes the whole word through a load port, and that is the only way to clear sticky flags. The current word is always visible on a read port.

Top module: `fp_status_acc`

## Requirements
- R1: `round_mode` equals status bits 10:9, with these encodings: 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity.
- R2: `flush_zero` equals status bit 5. It governs flushing of both results and operands.
- R3: The `raw_flags` bit order is: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. On an accepted operation each raised flag sets its sticky bit in the status word: inexact sets bit 27, underflow bit 28, overflow bit 29, divide-by-zero bit 30 and invalid bit 31.
- R4: An operation update never clears status bits 31:27 and never changes status bits 26:0. Only a load or a reset clears them.
- R5: When `load_en` is high, the next cycle shows `load_word` as the whole status word. A load in the same cycle as `op_done` wins: no flag is merged and no trap is raised.
- R6: An `op_done` with all raw flags low leaves the status word unchanged and raises no trap.
- R7: `trap` is high for exactly the one cycle in which the merged word first appears. It is raised only if some reported flag's mapped bit is also set in the enable bits, status bits 4:0. Those enable bits use the same order as bits 31:27: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid.
- R8: `raw_flags` are ignored while `op_done` is low. Each strobe merges its flags once.
- R9: After reset the status word is zero, `trap` is low, `round_mode` is 0 and `flush_zero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write `load_word` into the status word |
| load_word | input | 32 | New status word |
| op_done | input | 1 | Operation-complete strobe |
| raw_flags | input | 5 | Raw exception flags of the completed operation |
| round_mode | output | 2 | Decoded rounding direction |
| flush_zero | output | 1 | Flush-to-zero enable |
| trap | output | 1 | Assist trap pulse |
| status_word | output | 32 | Current status word |

## Verification
Every result of a load or an operation is due one clock edge after the inputs are sampled. The status word and the trap pulse appear together. The decoded controls follow the word combinationally in that same cycle.

The bench drives inputs on the falling edge and reads outputs one nanosecond after the rising edge that captured them. It checks that the trap has fallen by reading it again one edge later. The bench keeps its own expected status word, built from the flag positions in the requirements, and compares the read port against it after every step.

// File: rtl/fp_status_acc.sv
module fp_status_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  logic [31:0] load_word,
  input  logic        op_done,
  input  logic [4:0]  raw_flags,
  output logic [1:0]  round_mode,
  output logic        flush_zero,
  output logic        trap,
  output logic [31:0] status_word
);

  logic [31:0] sw_q;
  logic        trap_q;
  logic [4:0]  mapped;
  logic        merge;

  assign mapped = {raw_flags[0], raw_flags[1], raw_flags[2], raw_flags[3], raw_flags[4]};
  assign merge  = op_done && (|raw_flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      trap_q <= 1'b0;
    end else if (load_en) begin
      sw_q   <= load_word;
      trap_q <= 1'b0;
    end else if (merge) begin
      sw_q[31:27] <= sw_q[31:27] | mapped;
      trap_q      <= |(mapped & sw_q[4:0]);
    end else begin
      trap_q <= 1'b0;
    end
  end

  assign status_word = sw_q;
  assign trap        = trap_q;
  assign round_mode  = sw_q[10:9];
  assign flush_zero  = sw_q[5];

endmodule

module fp_status_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_en,
  input logic [31:0] load_word,
  input logic        op_done,
  input logic [4:0]  raw_flags,
  input logic        trap,
  input logic [31:0] status_word
);

  a_r5_load_takes_word: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> status_word == $past(load_word));

  a_r5_load_blocks_trap: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !trap);

  a_r6_no_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !(op_done && |raw_flags)) |=> $stable(status_word));

  a_r4_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ((status_word[31:27] & $past(status_word[31:27])) == $past(status_word[31:27])));

  a_r4_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> status_word[26:0] == $past(status_word[26:0]));

  a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> ($past(op_done) && !$past(load_en) && |$past(raw_flags)));

  a_r8_no_strobe_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> !trap);

endmodule

bind fp_status_acc fp_status_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_word(load_word),
  .op_done(op_done), .raw_flags(raw_flags), .trap(trap), .status_word(status_word)
);

// File: tb/fp_status_acc_bench.sv
`timescale 1ns/100ps
module fp_status_acc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_word = '0;
  logic        op_done = 1'b0;
  logic [4:0]  raw_flags = '0;
  logic [1:0]  round_mode;
  logic        flush_zero;
  logic        trap;
  logic [31:0] status_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_sw = '0;

  always #2.5 clk = ~clk;

  fp_status_acc u_fp_status_acc (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_word(load_word),
    .op_done(op_done), .raw_flags(raw_flags), .round_mode(round_mode),
    .flush_zero(flush_zero), .trap(trap), .status_word(status_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sticky_of(input logic [4:0] f);
    logic [31:0] s = '0;
    if (f[4]) s[27] = 1'b1;
    if (f[3]) s[28] = 1'b1;
    if (f[2]) s[29] = 1'b1;
    if (f[1]) s[30] = 1'b1;
    if (f[0]) s[31] = 1'b1;
    return s;
  endfunction

  task automatic do_load(input logic [31:0] w);
    @(negedge clk);
    load_en = 1'b1; load_word = w;
    @(posedge clk); #1;
    load_en = 1'b0;
    exp_sw = w;
    check("R5 load", status_word, exp_sw);
  endtask

  task automatic do_op(input logic [4:0] f, input logic exp_trap, input string req);
    @(negedge clk);
    op_done = 1'b1; raw_flags = f;
    @(posedge clk); #1;
    op_done = 1'b0; raw_flags = '0;
    exp_sw = exp_sw | sticky_of(f);
    check(req, status_word, exp_sw);
    check({req, " trap"}, {31'b0, trap}, {31'b0, exp_trap});
    @(posedge clk); #1;
    check("R7 trap single cycle", {31'b0, trap}, 32'd0);
  endtask

  task automatic t_reset;
    check("R9 status", status_word, 32'd0);
    check("R9 trap", {31'b0, trap}, 32'd0);
    check("R9 round", {30'b0, round_mode}, 32'd0);
    check("R9 flush", {31'b0, flush_zero}, 32'd0);
  endtask

  task automatic t_decode;
    for (int m = 0; m < 4; m++) begin
      do_load(32'(m) << 9);
      check("R1 round", {30'b0, round_mode}, 32'(m));
      check("R2 flush off", {31'b0, flush_zero}, 32'd0);
    end
    do_load(32'h0000_0420);
    check("R2 flush on", {31'b0, flush_zero}, 32'd1);
    check("R1 round toward +inf", {30'b0, round_mode}, 32'd2);
  endtask

  task automatic t_mapping;
    for (int b = 0; b < 5; b++) begin
      do_load(32'h0000_0000);
      do_op(5'(1 << b), 1'b0, "R3 flag position");
    end
  endtask

  task automatic t_sticky;
    do_load(32'h0000_0200);
    do_op(5'b00001, 1'b0, "R3 invalid");
    do_op(5'b10000, 1'b0, "R4 sticky invalid kept");
    do_op(5'b00000, 1'b0, "R6 empty op");
    check("R4 low bits", status_word & 32'h07FF_FFFF, 32'h0000_0200);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    raw_flags = 5'b11111;
    @(posedge clk); #1;
    @(posedge clk); #1;
    raw_flags = '0;
    check("R8 no strobe status", status_word, exp_sw);
    check("R8 no strobe trap", {31'b0, trap}, 32'd0);
  endtask

  task automatic t_trap;
    do_load(32'h0000_0004);
    do_op(5'b01000, 1'b0, "R7 disabled underflow");
    do_op(5'b00100, 1'b1, "R7 enabled overflow");
    do_op(5'b00100, 1'b1, "R7 repeat overflow");
    do_load(32'h0000_001F);
    do_op(5'b00010, 1'b1, "R7 enabled divzero");
    do_op(5'b00000, 1'b0, "R7 empty op no trap");
  endtask

  task automatic t_priority;
    do_load(32'h0000_001F);
    @(negedge clk);
    load_en = 1'b1; load_word = 32'h0000_061F;
    op_done = 1'b1; raw_flags = 5'b11111;
    @(posedge clk); #1;
    load_en = 1'b0; op_done = 1'b0; raw_flags = '0;
    exp_sw = 32'h0000_061F;
    check("R5 load wins status", status_word, exp_sw);
    check("R5 load wins trap", {31'b0, trap}, 32'd0);
    do_load(32'h0000_0000);
    check("R5 load clears sticky", status_word, 32'd0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_decode();
    t_mapping();
    t_sticky();
    t_ignore();
    t_trap();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule